// File: doc/BRIEF.md
# DDS Multi-Waveform Audio Oscillator

This block is a direct digital synthesis tone source for an audio path that runs on one fast system clock. A 24-bit phase register moves forward only in cycles where a periodic phase-enable strobe is high, adding a programmable frequency word each time. From the phase, and from a free-running pseudo-random shift register, the block forms five signed 16-bit waveforms: sawtooth, square, variable-width pulse, triangle and noise. A 3-bit select chooses which one goes out. The chosen sample is registered on each strobe and presented as a valid/data pair.

Configuration comes in over a byte-wide write port. The 24-bit frequency word spans three addresses. The two lower bytes are only staged in shadow registers. The write of the top byte moves the complete word into the running register in a single cycle, so the pitch never passes through a mixed old/new value. The same port also sets the waveform select and the pulse width. The output has no ready input because a tone source cannot stall. A sample that the consumer does not take in its valid cycle is lost, and the consumer must accept one sample per strobe.

Top module: `dds_wave_osc`

## Requirements
- R1: After reset the phase is 0. In each cycle where `phase_en` is high, the phase becomes phase + frequency word modulo 2^24. In other cycles it holds.
- R2: A write to 0x30 or 0x31 only stages the low or middle byte and leaves the running frequency word unchanged. A write to 0x32 sets the running word to {data, byte staged at 0x31, byte staged at 0x30} at the next clock edge. A strobe in the same cycle as that write still adds the old word.
- R3: Sawtooth (select 0) is phase[23:8] with bit 15 inverted, so phase 0 gives 0x8000 (-32768).
- R4: Square (select 1) is 0x7FFF when phase[23] is 1 and 0x8000 otherwise.
- R5: Pulse (select 2) is 0x7FFF when phase < (width << 16) and 0x8000 otherwise. Width 0 therefore always gives 0x8000.
- R6: Triangle (select 3) takes t = phase[22:0] when phase[23] is 0, or ~phase[22:0] when it is 1. The output is t[22:7] with bit 15 inverted.
- R7: Noise (select 4) is bits [22:7] of a 23-bit shift register that resets to 1. On every strobe it shifts left and takes bit22 XOR bit17 into bit 0. The register steps on every strobe, whichever wave is selected.
- R8: Select values 5, 6 and 7 give the sample 0.
- R9: A write to 0x33 sets the select from data[2:0], and the upper data bits have no effect. A write to 0x34 sets the 8-bit pulse width.
- R10: Writes to any address outside 0x30 to 0x34 change no setting.
- R11: At a clock edge where `phase_en` is high, `smp_data` takes the wave computed from the phase, noise state and settings held before that edge. `smp_valid` is high in exactly the one cycle that follows each strobe edge. Between strobes `smp_data` holds.
- R12: After reset `smp_valid` is 0, `smp_data` is 0, and the frequency word, select, pulse width and staged bytes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_en | input | 1 | Phase-advance strobe, one cycle wide |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| smp_valid | output | 1 | Sample valid, one cycle after each strobe |
| smp_data | output | 16 | Signed sample, two's complement |

## Verification
A frequency commit and a phase strobe can land in the same cycle. Both the phase adder and the word register then act on one edge, and the phase must take the old word for that step and the new word from the next step on. The bench drives a write to 0x32 together with `phase_en` high. It then follows with sawtooth samples, whose values expose the phase directly, and compares them against a phase model that applies the new word one step late. A select write that coincides with a strobe is judged the same way: that sample still uses the old select.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int SEL_W   = 3;
  localparam int N_WAVES = 5;

  typedef enum logic [SEL_W-1:0] {
    WAV_SAW = 3'd0,
    WAV_SQR = 3'd1,
    WAV_PLS = 3'd2,
    WAV_TRI = 3'd3,
    WAV_NSE = 3'd4
  } wave_sel_e;
endpackage

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs #(
  parameter int         PHASE_W   = 24,
  parameter int         PW_W      = 8,
  parameter int         SEL_W     = 3,
  parameter logic [7:0] BASE_ADDR = 8'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic [PHASE_W-1:0] freq_word,
  output logic [SEL_W-1:0]   wave_sel,
  output logic [PW_W-1:0]    pulse_width
);
  localparam int         NB          = PHASE_W / 8;
  localparam int         SH_W        = (NB - 1) * 8;
  localparam logic [7:0] ADDR_COMMIT = BASE_ADDR + 8'(NB - 1);
  localparam logic [7:0] ADDR_SEL    = BASE_ADDR + 8'(NB);
  localparam logic [7:0] ADDR_PW     = BASE_ADDR + 8'(NB + 1);

  logic [SH_W-1:0] staged;

  for (genvar gi = 0; gi < NB - 1; gi++) begin : g_shadow
    localparam logic [7:0] MY_ADDR = BASE_ADDR + 8'(gi);
    logic [7:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           sh_q <= '0;
      else if (wr_en && wr_addr == MY_ADDR) sh_q <= wr_data;
    end
    assign staged[gi*8 +: 8] = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_word   <= '0;
      wave_sel    <= '0;
      pulse_width <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_COMMIT) freq_word   <= {wr_data, staged};
      if (wr_addr == ADDR_SEL)    wave_sel    <= wr_data[SEL_W-1:0];
      if (wr_addr == ADDR_PW)     pulse_width <= wr_data[PW_W-1:0];
    end
  end

  // R2: staging writes leave the running word alone
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= BASE_ADDR && wr_addr < ADDR_COMMIT) |=> $stable(freq_word));

  // R2: commit carries the written byte to the top of the word
  p_commit_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_COMMIT) |=> freq_word[PHASE_W-1 -: 8] == $past(wr_data));

  // R10: writes outside the window change no setting
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < BASE_ADDR || wr_addr > ADDR_PW))
      |=> ($stable(freq_word) && $stable(wave_sel) && $stable(pulse_width) && $stable(staged)));
endmodule

// File: rtl/osc_phase_acc.sv
module osc_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_en,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= '0;
    else if (phase_en) phase <= phase + freq_word;
  end

  // R1: phase only moves on a strobe
  p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |=> $stable(phase));

  // R1: a strobe advances by the word held before the edge, modulo 2^W
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_en |=> (phase - $past(phase)) == $past(freq_word));
endmodule

// File: rtl/osc_noise_lfsr.sv
module osc_noise_lfsr #(
  parameter int LFSR_W = 23,
  parameter int TAP_A  = 22,
  parameter int TAP_B  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic fb;
  assign fb = state[TAP_A] ^ state[TAP_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= LFSR_W'(1);
    else if (step) state <= {state[LFSR_W-2:0], fb};
  end

  // R7: a nonzero seed never reaches the all-zero lock state
  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R7: each strobe shifts the register by one position
  p_lfsr_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state[LFSR_W-1:1] == $past(state[LFSR_W-2:0]));

  // R7: no strobe, no step
  p_lfsr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/osc_wave_shaper.sv
module osc_wave_shaper #(
  parameter int PHASE_W = 24,
  parameter int SMP_W   = 16,
  parameter int PW_W    = 8
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic [PW_W-1:0]    pulse_width,
  output logic [SMP_W-1:0]   saw,
  output logic [SMP_W-1:0]   sqr,
  output logic [SMP_W-1:0]   pls,
  output logic [SMP_W-1:0]   tri_w
);
  localparam logic [SMP_W-1:0] FS_POS = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] FS_NEG = {1'b1, {(SMP_W-1){1'b0}}};

  logic [PHASE_W-1:0] pw_thresh;
  logic [PHASE_W-2:0] folded;

  assign pw_thresh = {pulse_width, {(PHASE_W-PW_W){1'b0}}};
  assign folded    = phase[PHASE_W-1] ? ~phase[PHASE_W-2:0] : phase[PHASE_W-2:0];

  always_comb begin
    saw   = {~phase[PHASE_W-1], phase[PHASE_W-2 -: SMP_W-1]};
    sqr   = phase[PHASE_W-1] ? FS_POS : FS_NEG;
    pls   = (phase < pw_thresh) ? FS_POS : FS_NEG;
    tri_w = {~folded[PHASE_W-2], folded[PHASE_W-3 -: SMP_W-1]};
  end
endmodule

// File: rtl/dds_wave_osc.sv
module dds_wave_osc #(
  parameter int         PHASE_W   = 24,
  parameter int         SMP_W     = 16,
  parameter int         PW_W      = 8,
  parameter int         LFSR_W    = 23,
  parameter int         TAP_A     = 22,
  parameter int         TAP_B     = 17,
  parameter logic [7:0] BASE_ADDR = 8'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             smp_valid,
  output logic [SMP_W-1:0] smp_data
);
  import osc_pkg::*;

  logic [PHASE_W-1:0] freq_word;
  logic [SEL_W-1:0]   wave_sel;
  logic [PW_W-1:0]    pulse_width;
  logic [PHASE_W-1:0] phase;
  logic [LFSR_W-1:0]  lfsr;
  logic [N_WAVES-1:0][SMP_W-1:0] waves;
  logic [SMP_W-1:0]   pick;

  osc_cfg_regs #(
    .PHASE_W(PHASE_W), .PW_W(PW_W), .SEL_W(SEL_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_word(freq_word), .wave_sel(wave_sel), .pulse_width(pulse_width)
  );

  osc_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .freq_word(freq_word), .phase(phase)
  );

  osc_noise_lfsr #(.LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_noise (
    .clk(clk), .rst_n(rst_n), .step(phase_en), .state(lfsr)
  );

  osc_wave_shaper #(.PHASE_W(PHASE_W), .SMP_W(SMP_W), .PW_W(PW_W)) u_shape (
    .phase(phase), .pulse_width(pulse_width),
    .saw(waves[WAV_SAW]), .sqr(waves[WAV_SQR]), .pls(waves[WAV_PLS]), .tri_w(waves[WAV_TRI])
  );

  assign waves[WAV_NSE] = lfsr[LFSR_W-1 -: SMP_W];

  always_comb begin
    if (wave_sel < SEL_W'(N_WAVES)) pick = waves[wave_sel];
    else                            pick = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_valid <= phase_en;
      if (phase_en) smp_data <= pick;
    end
  end

  // R11: valid follows each strobe by exactly one cycle
  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase_en |=> smp_valid);
  p_valid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |=> !smp_valid);
  // R11: sample holds between strobes
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |=> $stable(smp_data));
  // R8: unused selects output silence
  p_silence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_en && wave_sel >= SEL_W'(N_WAVES)) |=> smp_data == '0);
  // R4: square only ever takes the two full-scale values
  p_square_rails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_en && wave_sel == WAV_SQR)
      |=> (smp_data == {1'b0, {(SMP_W-1){1'b1}}} || smp_data == {1'b1, {(SMP_W-1){1'b0}}}));
endmodule

// File: tb/dds_wave_osc_tb.sv
module dds_wave_osc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        smp_valid;
  logic [15:0] smp_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state
  logic [23:0] m_phase = '0;
  logic [22:0] m_lfsr  = 23'd1;
  logic [23:0] m_freq  = '0;
  logic [7:0]  m_lo = '0, m_mid = '0, m_pw = '0;
  logic [2:0]  m_sel = '0;
  logic [15:0] m_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_wave_osc u_dut (
    .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .smp_valid(smp_valid), .smp_data(smp_data)
  );

  function automatic logic [15:0] exp_wave(logic [2:0] s, logic [23:0] p,
                                           logic [22:0] l, logic [7:0] w);
    logic [22:0] t;
    case (s)
      3'd0: return {~p[23], p[22:8]};                       // R3
      3'd1: return p[23] ? 16'h7FFF : 16'h8000;             // R4
      3'd2: return (p < {w, 16'h0000}) ? 16'h7FFF : 16'h8000; // R5
      3'd3: begin                                            // R6
        t = p[23] ? ~p[22:0] : p[22:0];
        return {~t[22], t[21:7]};
      end
      3'd4: return l[22:7];                                  // R7
      default: return 16'h0000;                              // R8
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic pe, input logic we, input logic [7:0] a,
                      input logic [7:0] d, input string tag);
    logic [15:0] e;
    phase_en = pe; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (pe) begin
      e       = exp_wave(m_sel, m_phase, m_lfsr, m_pw);
      m_last  = e;
      m_phase = m_phase + m_freq;
      m_lfsr  = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
    end
    if (we) begin
      case (a)
        8'h30: m_lo  = d;
        8'h31: m_mid = d;
        8'h32: m_freq = {d, m_mid, m_lo};
        8'h33: m_sel = d[2:0];
        8'h34: m_pw  = d;
        default: ;
      endcase
    end
    @(negedge clk);
    phase_en = 1'b0; wr_en = 1'b0;
    if (pe) begin
      check({tag, " valid"}, {31'd0, smp_valid}, 32'd1);
      check(tag, {16'd0, smp_data}, {16'd0, m_last});
    end else if (!we) begin
      check("R11 idle", {15'd0, smp_valid, smp_data}, {15'd0, 1'b0, m_last});
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 8'h00, 8'h00, tag);
      if (i % 3 == 0) step(1'b0, 1'b0, 8'h00, 8'h00, tag);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d, "R9");
  endtask

  task automatic set_freq(input logic [23:0] f);
    wr(8'h30, f[7:0]);
    wr(8'h31, f[15:8]);
    wr(8'h32, f[23:16]);
  endtask

  initial begin
    string sel_tag [8];
    sel_tag[0] = "R3"; sel_tag[1] = "R4"; sel_tag[2] = "R5"; sel_tag[3] = "R6";
    sel_tag[4] = "R7"; sel_tag[5] = "R8"; sel_tag[6] = "R8"; sel_tag[7] = "R8";

    repeat (3) @(negedge clk);
    check("R12 valid", {31'd0, smp_valid}, 32'd0);
    check("R12 data", {16'd0, smp_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 data after release", {15'd0, smp_valid, smp_data}, 32'd0);

    // zero word: phase stays 0, saw sits at -32768
    run(4, "R12");
    run(2, "R1");

    // staging bytes alone do not move the pitch
    wr(8'h30, 8'h56);
    run(3, "R2");
    wr(8'h31, 8'h34);
    run(3, "R2");
    wr(8'h32, 8'h12);
    run(6, "R2");

    // every select, upper data bits set to prove they are ignored
    wr(8'h34, 8'h80);
    set_freq(24'h0A3D71);
    for (int s = 0; s < 8; s++) begin
      wr(8'h33, {5'b10101, 3'(s)});
      run(48, sel_tag[s]);
    end

    // pulse width corners
    wr(8'h33, 8'h02);
    wr(8'h34, 8'h00);
    run(24, "R5");
    wr(8'h34, 8'h01);
    set_freq(24'h004000);
    run(24, "R5");
    wr(8'h34, 8'hFF);
    set_freq(24'h1F0000);
    run(24, "R5");

    // out-of-window writes change nothing
    wr(8'h33, 8'h00);
    step(1'b0, 1'b1, 8'h2F, 8'hFF, "R10");
    step(1'b0, 1'b1, 8'h35, 8'h03, "R10");
    step(1'b0, 1'b1, 8'h36, 8'h77, "R10");
    step(1'b0, 1'b1, 8'hFF, 8'h04, "R10");
    run(12, "R10");

    // commit and strobe in the same cycle
    wr(8'h30, 8'h00);
    wr(8'h31, 8'h00);
    step(1'b1, 1'b1, 8'h32, 8'h40, "R2");
    run(8, "R2");
    // select change coinciding with a strobe
    step(1'b1, 1'b1, 8'h33, 8'h01, "R9");
    run(6, "R9");

    // wrap-around with an all-ones word
    wr(8'h33, 8'h00);
    set_freq(24'hFFFFFF);
    run(10, "R1");
    set_freq(24'hC00001);
    run(10, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule